// File: doc/BRIEF.md
# Spin-Lock Acquirer with Backoff

This block holds a single-bit lock word in a small shared store and places several requester engines in front of it. Each engine takes a one-cycle acquire pulse. It then polls the lock word with plain reads and tries an atomic exchange only after a read has returned free. When a check fails, because a read returned owned or an exchange returned owned, the engine waits out a backoff interval before it polls again. That interval doubles after every failure, up to a ceiling. A release pulse to the owning engine writes zero to the lock word.

All engines share one memory port. A fixed-priority selector serves one command per cycle, so an exchange reads and sets the word in one indivisible step. The port activity and the lock word are visible at the top level, which makes the polling pattern observable.

Top module: `spin_lock_unit`

## Requirements
- R1: After reset no engine is granted or busy, the lock word is 0 (free) and no memory command is issued (`mem_valid` low, `mem_op` 0).
- R2: A release pulse to the engine that owns the lock issues one write command (`mem_op` 3) that sets the lock word to 0. Its `granted` drops in the cycle after that write. A release pulse to an engine that does not own the lock changes nothing.
- R3: An acquire starts with a read command (`mem_op` 1). The engine becomes granted only when an exchange command (`mem_op` 2) returns old value 0, and `granted` rises in the cycle after that exchange.
- R4: An exchange is issued only directly after a read that returned 0. A read that returns 1 leads to backoff and no exchange.
- R5: An exchange that returns old value 1 does not grant the lock. The engine stays busy, backs off and then polls again.
- R6: The first failed check waits 1 cycle. Each further failure doubles the wait, which saturates at `BO_MAX` cycles. On an otherwise free port, successive reads therefore lie wait+1 cycles apart, and every new acquire restarts the wait at 1.
- R7: `granted` stays high from the winning exchange until the release write has been served.
- R8: At most one engine is granted at any time, and while any engine is granted the lock word is 1.
- R9: The port serves at most one command per cycle. When several engines request, the lowest index is served. `mem_src` gives the served engine and `mem_old` gives the lock word value before the command.
- R10: An acquire pulse to an engine that is already busy or granted is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_req | input | NUM_REQ | Per-engine acquire pulse |
| rel_req | input | NUM_REQ | Per-engine release pulse |
| granted | output | NUM_REQ | Engine owns the lock |
| busy | output | NUM_REQ | Engine is polling, backing off, exchanging or releasing |
| mem_valid | output | 1 | A memory command is served this cycle |
| mem_op | output | 2 | Served command: 1 read, 2 exchange, 3 write zero, 0 none |
| mem_src | output | SRC_W | Index of the served engine (0 when idle) |
| mem_old | output | 1 | Lock word value before this cycle's command |
| lock_word | output | 1 | Current lock word |

## Verification
The in-line properties watch the invariants on every cycle: mutual exclusion, a one-hot port grant, the lock word follows exchange and write commands, no exchange after a read of owned, grant held until the release write, and a backoff length that is always a power of two within bounds. What they cannot show is the exact pacing of the doubling sequence, its restart on a new acquire, the race in which two engines both read free and one loses the exchange, and the ignoring of stray pulses. The bench's reference model and directed scenarios cover these by measuring read spacing and counting lost exchanges.

// File: rtl/spinlock_pkg.sv
package spinlock_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_XCHG  = 2'd2,
    OP_WRITE = 2'd3
  } lk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_XCHG,
    ST_WAIT,
    ST_OWN,
    ST_FREE
  } eng_st_e;

  // doubled backoff, clipped at the ceiling
  function automatic int unsigned next_backoff(int unsigned cur, int unsigned limit);
    int unsigned dbl;
    dbl = cur * 2;
    return (dbl > limit) ? limit : dbl;
  endfunction

endpackage

// File: rtl/lock_word_mem.sv
module lock_word_mem
  import spinlock_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cmd_valid_i,
  input  lk_op_e cmd_op_i,
  output logic   old_o,
  output logic   word_o
);

  logic word_q;

  assign old_o  = word_q;
  assign word_o = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= 1'b0;
    end else if (cmd_valid_i) begin
      case (cmd_op_i)
        OP_XCHG:  word_q <= 1'b1;
        OP_WRITE: word_q <= 1'b0;
        default:  word_q <= word_q;
      endcase
    end
  end

  AST_XCHG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == OP_XCHG) |=> word_o); // R3
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == OP_WRITE) |=> !word_o); // R2
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == OP_READ) |=> $stable(word_o)); // R4

endmodule

// File: rtl/lock_port_arb.sv
module lock_port_arb
  import spinlock_pkg::*;
#(
  parameter int NUM_REQ = 3,
  localparam int SRC_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_REQ-1:0]      req_i,
  input  logic [NUM_REQ-1:0][1:0] op_i,
  output logic [NUM_REQ-1:0]      gnt_o,
  output logic                    valid_o,
  output lk_op_e                  op_o,
  output logic [SRC_W-1:0]        src_o
);

  always_comb begin
    gnt_o   = '0;
    valid_o = 1'b0;
    op_o    = OP_NONE;
    src_o   = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (req_i[i] && !valid_o) begin
        valid_o  = 1'b1;
        gnt_o[i] = 1'b1;
        op_o     = lk_op_e'(op_i[i]);
        src_o    = SRC_W'(i);
      end
    end
  end

  AST_ONE_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o)); // R9
  AST_SERVE_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o & ~req_i) == '0); // R9
  AST_NO_IDLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> valid_o); // R9

endmodule

// File: rtl/spinlock_engine.sv
module spinlock_engine
  import spinlock_pkg::*;
#(
  parameter int BO_MAX  = 256,
  localparam int BO_W   = $clog2(BO_MAX) + 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   acq_i,
  input  logic   rel_i,
  input  logic   port_gnt_i,
  input  logic   port_old_i,
  output logic   port_req_o,
  output lk_op_e port_op_o,
  output logic   granted_o,
  output logic   busy_o
);

  eng_st_e         st;
  logic [BO_W-1:0] bo_len;
  logic [BO_W-1:0] bo_cnt;

  // named events for the properties
  logic poll_hit_free, poll_hit_held, xchg_won, xchg_lost, fail_evt, rel_done;

  assign poll_hit_free = (st == ST_POLL) && port_gnt_i && !port_old_i;
  assign poll_hit_held = (st == ST_POLL) && port_gnt_i &&  port_old_i;
  assign xchg_won      = (st == ST_XCHG) && port_gnt_i && !port_old_i;
  assign xchg_lost     = (st == ST_XCHG) && port_gnt_i &&  port_old_i;
  assign fail_evt      = poll_hit_held || xchg_lost;
  assign rel_done      = (st == ST_FREE) && port_gnt_i;

  always_comb begin
    port_req_o = 1'b0;
    port_op_o  = OP_NONE;
    case (st)
      ST_POLL: begin port_req_o = 1'b1; port_op_o = OP_READ;  end
      ST_XCHG: begin port_req_o = 1'b1; port_op_o = OP_XCHG;  end
      ST_FREE: begin port_req_o = 1'b1; port_op_o = OP_WRITE; end
      default: begin port_req_o = 1'b0; port_op_o = OP_NONE;  end
    endcase
  end

  assign granted_o = (st == ST_OWN) || (st == ST_FREE);
  assign busy_o    = (st == ST_POLL) || (st == ST_XCHG) ||
                     (st == ST_WAIT) || (st == ST_FREE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      bo_len <= BO_W'(1);
      bo_cnt <= BO_W'(1);
    end else if (fail_evt) begin
      st     <= ST_WAIT;
      bo_cnt <= bo_len;
      bo_len <= BO_W'(next_backoff(int'(bo_len), BO_MAX));
    end else begin
      case (st)
        ST_IDLE: if (acq_i) begin
          st     <= ST_POLL;
          bo_len <= BO_W'(1);
        end
        ST_POLL: if (poll_hit_free) st <= ST_XCHG;
        ST_XCHG: if (xchg_won) st <= ST_OWN;
        ST_WAIT: begin
          if (bo_cnt == BO_W'(1)) st <= ST_POLL;
          else                    bo_cnt <= bo_cnt - BO_W'(1);
        end
        ST_OWN:  if (rel_i) st <= ST_FREE;
        ST_FREE: if (rel_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_WIN_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_won |=> granted_o); // R3
  AST_XCHG_AFTER_FREE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_XCHG) |-> $past(poll_hit_free)); // R4
  AST_HELD_READ_NO_XCHG: assert property (@(posedge clk) disable iff (!rst_n)
    poll_hit_held |=> !(port_req_o && port_op_o == OP_XCHG)); // R4
  AST_LOST_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_lost |=> (!granted_o && busy_o)); // R5
  AST_BACKOFF_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bo_len) == 1) && (int'(bo_len) <= BO_MAX)); // R6
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (granted_o && !rel_done) |=> granted_o); // R7
  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    rel_done |=> !granted_o); // R2

endmodule

// File: rtl/spin_lock_unit.sv
module spin_lock_unit
  import spinlock_pkg::*;
#(
  parameter int NUM_REQ = 3,
  parameter int BO_MAX  = 256,
  localparam int SRC_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] acq_req,
  input  logic [NUM_REQ-1:0] rel_req,
  output logic [NUM_REQ-1:0] granted,
  output logic [NUM_REQ-1:0] busy,
  output logic               mem_valid,
  output logic [1:0]         mem_op,
  output logic [SRC_W-1:0]   mem_src,
  output logic               mem_old,
  output logic               lock_word
);

  logic [NUM_REQ-1:0]      eng_req;
  logic [NUM_REQ-1:0][1:0] eng_op;
  logic [NUM_REQ-1:0]      eng_gnt;
  lk_op_e                  sel_op;
  logic                    word_old;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_eng
    lk_op_e op_g;
    spinlock_engine #(.BO_MAX(BO_MAX)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .acq_i      (acq_req[g]),
      .rel_i      (rel_req[g]),
      .port_gnt_i (eng_gnt[g]),
      .port_old_i (word_old),
      .port_req_o (eng_req[g]),
      .port_op_o  (op_g),
      .granted_o  (granted[g]),
      .busy_o     (busy[g])
    );
    assign eng_op[g] = op_g;
  end

  lock_port_arb #(.NUM_REQ(NUM_REQ)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (eng_req),
    .op_i    (eng_op),
    .gnt_o   (eng_gnt),
    .valid_o (mem_valid),
    .op_o    (sel_op),
    .src_o   (mem_src)
  );

  lock_word_mem u_mem (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (mem_valid),
    .cmd_op_i    (sel_op),
    .old_o       (word_old),
    .word_o      (lock_word)
  );

  assign mem_op  = sel_op;
  assign mem_old = word_old;

  AST_MUTEX: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(granted) <= 1); // R8
  AST_OWNER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (|granted) |-> lock_word); // R8

endmodule

// File: tb/sim_spin_lock_unit.sv
module sim_spin_lock_unit;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 3;
  localparam int BOM = 16;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] acq = '0;
  logic [N-1:0] rel = '0;
  logic [N-1:0] granted, busy;
  logic mem_valid, mem_old, lock_word;
  logic [1:0] mem_op, mem_src;

  always #(CLK_PERIOD/2) clk = ~clk;

  spin_lock_unit #(.NUM_REQ(N), .BO_MAX(BOM)) u0 (
    .clk(clk), .rst_n(rst_n), .acq_req(acq), .rel_req(rel),
    .granted(granted), .busy(busy), .mem_valid(mem_valid), .mem_op(mem_op),
    .mem_src(mem_src), .mem_old(mem_old), .lock_word(lock_word)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phases: 0 idle, 1 polling read, 2 exchange, 3 waiting, 4 owner, 5 releasing
  int ph[N];
  int wlen[N];
  int wcnt[N];
  int mlock;

  function automatic int serving();
    for (int i = 0; i < N; i++)
      if (ph[i] == 1 || ph[i] == 2 || ph[i] == 5) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin ph[i] = 0; wlen[i] = 1; wcnt[i] = 1; end
      mlock = 0;
    end else begin
      int s;
      int sop;
      int old;
      s = serving();
      sop = (s >= 0) ? ph[s] : 0;
      old = mlock;
      for (int i = 0; i < N; i++) begin
        case (ph[i])
          0: if (acq[i]) begin ph[i] = 1; wlen[i] = 1; end
          1, 2: if (s == i) begin
            if (old == 0) ph[i] = (ph[i] == 1) ? 2 : 4;
            else begin
              wcnt[i] = wlen[i];
              wlen[i] = (wlen[i] * 2 > BOM) ? BOM : wlen[i] * 2;
              ph[i] = 3;
            end
          end
          3: if (wcnt[i] == 1) ph[i] = 1; else wcnt[i]--;
          4: if (rel[i]) ph[i] = 5;
          5: if (s == i) ph[i] = 0;
          default: ;
        endcase
      end
      if (sop == 2) mlock = 1;
      if (sop == 5) mlock = 0;
    end
  end

  // ---------------- per-cycle comparison and monitors ----------------
  int rd1_t[$];
  int lost2 = 0;
  int xchg1 = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      int s;
      int eop;
      logic [N-1:0] eg, eb;
      s = serving();
      for (int i = 0; i < N; i++) begin
        eg[i] = (ph[i] == 4 || ph[i] == 5);
        eb[i] = (ph[i] == 1 || ph[i] == 2 || ph[i] == 3 || ph[i] == 5);
      end
      eop = (s < 0) ? 0 : (ph[s] == 1) ? 1 : (ph[s] == 2) ? 2 : 3;
      chk(granted == eg, "R7 granted vs model", int'(granted), int'(eg));
      chk(busy == eb, "R10 busy vs model", int'(busy), int'(eb));
      chk(mem_valid == (s >= 0) && int'(mem_op) == eop,
          "R9 port op vs model", int'(mem_op), eop);
      chk((s < 0) || int'(mem_src) == s, "R9 port source vs model", int'(mem_src), s);
      chk(int'(lock_word) == mlock && int'(mem_old) == mlock,
          "R2 lock word vs model", int'(lock_word), mlock);
      chk($countones(granted) <= 1, "R8 single owner", $countones(granted), 1);
      if (mem_valid && mem_op == 2'd1 && mem_src == 2'd1) rd1_t.push_back(cyc);
      if (mem_valid && mem_op == 2'd2 && mem_src == 2'd1) xchg1++;
      if (mem_valid && mem_op == 2'd2 && mem_src == 2'd2 && mem_old) lost2++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      chk(0, "watchdog expired", cyc, WATCHDOG);
      report();
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_acq(int i);
    acq[i] = 1'b1; @(negedge clk); acq[i] = 1'b0;
  endtask

  task automatic pulse_rel(int i);
    rel[i] = 1'b1; @(negedge clk); rel[i] = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(granted == 0 && busy == 0, "R1 reset outputs", int'({granted, busy}), 0);
    chk(!lock_word && !mem_valid && mem_op == 2'd0, "R1 reset lock/port",
        int'({lock_word, mem_valid, mem_op}), 0);

    // R3 lone acquire
    pulse_acq(0);
    idle(4);
    chk(granted[0] == 1'b1, "R3 lone acquire granted", int'(granted[0]), 1);

    // R10 acquire to owner ignored
    pulse_acq(0);
    idle(3);
    chk(busy[0] == 1'b0 && granted[0], "R10 owner acquire ignored",
        int'({busy[0], granted[0]}), 1);
    // R2 stray release ignored
    pulse_rel(1);
    idle(2);
    chk(lock_word && granted[0], "R2 stray release ignored",
        int'({lock_word, granted[0]}), 3);

    // R4 / R6 polling against a held lock
    rd1_t.delete();
    xchg1 = 0;
    pulse_acq(1);
    idle(120);
    chk(xchg1 == 0, "R4 no exchange while held", xchg1, 0);
    chk(rd1_t.size() >= 8, "R6 enough polls", rd1_t.size(), 8);
    begin
      int w;
      w = 1;
      for (int k = 1; k < rd1_t.size(); k++) begin
        chk(rd1_t[k] - rd1_t[k-1] == w + 1, "R6 poll spacing",
            rd1_t[k] - rd1_t[k-1], w + 1);
        w = (w * 2 > BOM) ? BOM : w * 2;
      end
    end

    // R2 release, R3 waiting engine takes over
    pulse_rel(0);
    idle(40);
    chk(granted == 3'b010, "R3 handover after release", int'(granted), 2);

    // R6 restart of the wait on a new acquire
    pulse_rel(1);
    idle(3);
    chk(!lock_word && granted == 0, "R2 release frees lock",
        int'({lock_word, granted}), 0);
    pulse_acq(0);
    idle(5);
    rd1_t.delete();
    pulse_acq(1);
    idle(12);
    chk(rd1_t.size() >= 2 && rd1_t[1] - rd1_t[0] == 2, "R6 wait restarts at one",
        (rd1_t.size() >= 2) ? rd1_t[1] - rd1_t[0] : -1, 2);
    pulse_rel(0);
    idle(40);
    pulse_rel(1);
    idle(5);

    // R5 lost exchange after a read of free
    lost2 = 0;
    pulse_acq(2);
    pulse_acq(1);
    idle(3);
    chk(lost2 >= 1, "R5 exchange lost", lost2, 1);
    chk(granted == 3'b010 && busy[2], "R5 loser not granted",
        int'({granted, busy[2]}), 5);
    pulse_rel(1);
    idle(60);
    pulse_rel(2);
    idle(5);

    // random traffic checked against the model
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++) begin
        acq[i] = ($urandom % 6) == 0;
        rel[i] = ($urandom % 5) == 0;
      end
      @(negedge clk);
    end
    acq = '0;
    rel = '0;
    idle(5);
    report();
  end

endmodule